// File: doc/BRIEF.md
# Tiny Single-Cycle 9-bit-Instruction Processor

This block is a minimal single-cycle processor core. It holds a 4-bit program counter, four 4-bit general registers with two combinational read ports and one clocked write port, a 16-word instruction store, an instruction decoder and a 4-bit ripple-carry ALU. Every rising clock edge retires exactly one instruction: the word at the current PC is decoded, two registers are read, the ALU computes, the result is written back, and the PC moves to its next value. There is no pipelining and no data memory.

An instruction is 9 bits wide. Bits [8:6] hold the opcode, [5:4] the first register field (called X here), [3:2] the second field (Y), and [1:0] either a third register field (Z) or a 2-bit signed offset. Arithmetic and logic instructions compute X <- Y op Z. The conditional branch compares registers X and Y. If they differ, it moves the PC by the sign-extended offset, relative to its own address. If they are equal, it falls through to PC+1.

The instruction store is filled through a load port. That port is honoured only while the core is held in reset, so it cannot corrupt a running program. The active-low reset asserts asynchronously. Its release is synchronised and reaches the core two clock edges after `rst_n` rises.

Top module: `tiny9_core`

## Requirements
- R1: Opcode 000 (add) writes Y+Z, wrapped to 4 bits, into register X. Opcode 000 with X=1, Y=0, Z=0 encodes as 9'h010.
- R2: Opcode 100 (subtract) writes Y-Z, wrapped to 4 bits, into register X.
- R3: Opcode 001 writes the bitwise complement of (Y AND Z) into register X.
- R4: Opcode 010 writes 1 into X when Y < Z as signed 4-bit values and 0 otherwise. The result is correct even when the subtraction Y-Z overflows, e.g. 1 < -8 gives 0. This opcode never redirects the PC.
- R5: Opcode 011 (branch) never writes a register. When X != Y, the next PC is PC + sign-extended offset, modulo 16. Offset 2'b11 means -1 and 2'b00 means 0, which holds the PC in place.
- R6: A branch whose two registers are equal sets the next PC to PC+1.
- R7: An add or subtract whose signed result overflows still writes the wrapped result to X, and sets the next PC to 4'b1111.
- R8: Every non-branch instruction that does not trigger R7 advances the PC by 1, and the PC wraps from 15 to 0.
- R9: Reset drives the PC to 0 at once, and clears all four registers to 0 by the time the first instruction executes.
- R10: The load port writes `load_data_i` into the instruction word at `load_addr_i` while reset is held. It is ignored while the core runs. `inst_o` always shows the word at the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en_i | input | 1 | Instruction store write strobe (honoured only in reset) |
| load_addr_i | input | 4 | Instruction store word address for a load |
| load_data_i | input | 9 | Instruction word to load |
| pc_o | output | 4 | Current program counter |
| inst_o | output | 9 | Instruction word at the current PC |
| wb_en_o | output | 1 | High when the current instruction writes a register |
| wb_addr_o | output | 2 | Register written by the current instruction |
| wb_data_o | output | 4 | Value written by the current instruction |

## Verification
A wrong register value shows at the ports in the cycle of the next instruction that reads that register. It appears either as a wrong `wb_data_o` or as a branch that goes the wrong way, so one PC sample later. A wrong PC shows in `pc_o` and `inst_o` immediately after the edge that produced it. The test program uses only register-to-register operations, so constants are built by chains of instructions. For that reason, one corrupted write spreads into every later result of the trace, and a loop closed by a backward branch counts through an overflow. Reset clearing is observed through self-branches that only fall through when a register reads as zero.

// File: rtl/tiny9_pkg.sv
package tiny9_pkg;

  // Architectural widths
  localparam int DATA_W = 4;   // register and ALU width
  localparam int RIDX_W = 2;   // register index width
  localparam int PC_W   = 4;   // program counter width
  localparam int OP_W   = 3;   // opcode width
  localparam int INST_W = OP_W + 3 * RIDX_W;

  typedef enum logic [OP_W-1:0] {
    OPC_ADD  = 3'b000,
    OPC_NAND = 3'b001,
    OPC_SLT  = 3'b010,
    OPC_BRNE = 3'b011,
    OPC_SUB  = 3'b100
  } opcode_e;

  // Instruction word: opcode, X, Y, Z/offset (MSB to LSB)
  typedef struct packed {
    opcode_e           op;
    logic [RIDX_W-1:0] fx;
    logic [RIDX_W-1:0] fy;
    logic [RIDX_W-1:0] fz;
  } inst_t;

  // One-hot ALU result select; a branch selects none
  typedef struct packed {
    logic use_lt;
    logic use_nand;
    logic use_add;
  } alu_sel_t;

endpackage

// File: rtl/t9_alu.sv
module t9_alu
  import tiny9_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  alu_sel_t      sel_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o,
  output logic          ovf_o
);

  localparam int MSB = DW - 1;

  logic [DW:0]   carry;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum;
  logic          sign_mix;
  logic          less;

  assign carry[0] = cin_i;

  // Ripple chain of full adders; carry-in inverts B for subtraction
  generate
    for (genvar i = 0; i < DW; i++) begin : g_fa
      assign b_eff[i]   = b_i[i] ^ cin_i;
      assign sum[i]     = a_i[i] ^ b_eff[i] ^ carry[i];
      assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
    end
  endgenerate

  assign ovf_o    = carry[DW] ^ carry[MSB];
  assign sign_mix = a_i[MSB] ^ b_i[MSB];
  // Opposite signs: A is smaller exactly when A is negative
  assign less     = sign_mix ? a_i[MSB] : sum[MSB];
  assign zero_o   = ~|(a_i ^ b_i);

  always_comb begin
    res_o = '0;
    if (sel_i.use_add)  res_o = res_o | sum;
    if (sel_i.use_nand) res_o = res_o | ~(a_i & b_i);
    if (sel_i.use_lt)   res_o = res_o | {{(DW-1){1'b0}}, less};
  end

  // R4
  always_comb begin
    if (sel_i.use_lt && !sel_i.use_add && !sel_i.use_nand && sign_mix) begin
      slt_mixed_sign_chk: assert (res_o == {{(DW-1){1'b0}}, a_i[MSB]});
    end
  end

endmodule

// File: rtl/t9_regfile.sv
module t9_regfile
  import tiny9_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = RIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);

  localparam int NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0]         row_en;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_row
      assign row_en[r] = we_i && (waddr_i == AW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[r] <= '0;
        end else if (row_en[r]) begin
          regs_q[r] <= wdata_i;
        end
      end
    end
  endgenerate

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R1
  rf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));

  // R9
  rf_onewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en));

endmodule

// File: rtl/t9_decoder.sv
module t9_decoder
  import tiny9_pkg::*;
#(
  parameter int AW = RIDX_W,
  parameter int PW = PC_W
) (
  input  logic [INST_W-1:0] inst_i,
  output logic              we_o,
  output logic [AW-1:0]     rd_a_o,
  output logic [AW-1:0]     rd_b_o,
  output logic [AW-1:0]     wr_o,
  output logic              cin_o,
  output alu_sel_t          sel_o,
  output logic              is_branch_o,
  output logic              is_arith_o,
  output logic [PW-1:0]     offs_o
);

  inst_t word;

  assign word   = inst_t'(inst_i);
  // Offset shares the Z field and is sign-extended to PC width
  assign offs_o = {{(PW-AW){word.fz[AW-1]}}, word.fz};
  assign wr_o   = word.fx;

  always_comb begin
    we_o        = 1'b1;
    rd_a_o      = word.fy;
    rd_b_o      = word.fz;
    cin_o       = 1'b0;
    sel_o       = '0;
    is_branch_o = 1'b0;
    is_arith_o  = 1'b0;
    unique case (word.op)
      OPC_ADD: begin
        sel_o.use_add = 1'b1;
        is_arith_o    = 1'b1;
      end
      OPC_SUB: begin
        sel_o.use_add = 1'b1;
        cin_o         = 1'b1;
        is_arith_o    = 1'b1;
      end
      OPC_NAND: begin
        sel_o.use_nand = 1'b1;
      end
      OPC_SLT: begin
        sel_o.use_lt = 1'b1;
        cin_o        = 1'b1;
      end
      OPC_BRNE: begin
        we_o        = 1'b0;
        rd_a_o      = word.fx;
        rd_b_o      = word.fy;
        cin_o       = 1'b1;
        is_branch_o = 1'b1;
      end
      default: begin
        we_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/t9_imem.sv
module t9_imem
  import tiny9_pkg::*;
#(
  parameter int IW = INST_W,
  parameter int PW = PC_W
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);

  localparam int DEPTH = 1 << PW;

  logic [IW-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      words_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = words_q[raddr_i];

endmodule

// File: rtl/tiny9_core.sv
module tiny9_core
  import tiny9_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = RIDX_W,
  parameter int PW = PC_W,
  parameter int IW = INST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en_i,
  input  logic [PW-1:0] load_addr_i,
  input  logic [IW-1:0] load_data_i,
  output logic [PW-1:0] pc_o,
  output logic [IW-1:0] inst_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);

  localparam int SYNC_STAGES = 2;
  localparam logic [PW-1:0] PC_TRAP = '1;
  localparam logic [PW-1:0] PC_STEP = PW'(1);

  // Reset synchroniser: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  logic [PW-1:0] pc_q, pc_d;
  logic [IW-1:0] inst;
  logic          rf_we, cin, is_branch, is_arith;
  logic [AW-1:0] rd_a, rd_b, wr_idx;
  logic [PW-1:0] offs;
  alu_sel_t      sel;
  logic [DW-1:0] opa, opb, alu_res;
  logic          alu_zero, alu_ovf, trap;

  t9_imem #(.IW(IW), .PW(PW)) u_imem (
    .clk     (clk),
    .we_i    (load_en_i & ~core_rst_n),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (pc_q),
    .rdata_o (inst)
  );

  t9_decoder #(.AW(AW), .PW(PW)) u_dec (
    .inst_i      (inst),
    .we_o        (rf_we),
    .rd_a_o      (rd_a),
    .rd_b_o      (rd_b),
    .wr_o        (wr_idx),
    .cin_o       (cin),
    .sel_o       (sel),
    .is_branch_o (is_branch),
    .is_arith_o  (is_arith),
    .offs_o      (offs)
  );

  t9_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .we_i      (rf_we),
    .waddr_i   (wr_idx),
    .wdata_i   (alu_res),
    .raddr_a_i (rd_a),
    .raddr_b_i (rd_b),
    .rdata_a_o (opa),
    .rdata_b_o (opb)
  );

  t9_alu #(.DW(DW)) u_alu (
    .a_i    (opa),
    .b_i    (opb),
    .cin_i  (cin),
    .sel_i  (sel),
    .res_o  (alu_res),
    .zero_o (alu_zero),
    .ovf_o  (alu_ovf)
  );

  assign trap = is_arith & alu_ovf;

  // Next-PC selection: overflow trap, taken branch, or sequential
  always_comb begin
    if (trap) begin
      pc_d = PC_TRAP;
    end else if (is_branch && !alu_zero) begin
      pc_d = pc_q + offs;
    end else begin
      pc_d = pc_q + PC_STEP;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o      = pc_q;
  assign inst_o    = inst;
  assign wb_en_o   = rf_we;
  assign wb_addr_o = wr_idx;
  assign wb_data_o = alu_res;

  // R7
  ovf_redirect_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_arith && alu_ovf) |=> pc_q == PC_TRAP);

  // R7
  ovf_still_writes_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_arith && alu_ovf) |-> rf_we);

  // R5
  br_taken_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_branch && !alu_zero) |=> pc_q == $past(pc_q) + $past(offs));

  // R5
  br_nowrite_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    is_branch |-> !rf_we);

  // R6
  br_fallthru_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (is_branch && alu_zero) |=> pc_q == $past(pc_q) + PC_STEP);

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!is_branch && !(is_arith && alu_ovf)) |=> pc_q == $past(pc_q) + PC_STEP);

  // R10
  load_blocked_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_en_i && pc_d == pc_q) |=> $stable(inst));

endmodule

// File: tb/tiny9_core_test.sv
module tiny9_core_test;

  localparam int CLK_P = 10;
  localparam int STEPS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [8:0] load_data = '0;
  logic [3:0] pc;
  logic [8:0] inst;
  logic       wb_en;
  logic [1:0] wb_addr;
  logic [3:0] wb_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tiny9_core uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en_i   (load_en),
    .load_addr_i (load_addr),
    .load_data_i (load_data),
    .pc_o        (pc),
    .inst_o      (inst),
    .wb_en_o     (wb_en),
    .wb_addr_o   (wb_addr),
    .wb_data_o   (wb_data)
  );

  always #(CLK_P/2) clk = ~clk;

  // Program for phase 1 (word index = address)
  localparam logic [8:0] PROG [16] = '{
    9'h050, 9'h121, 9'h03A, 9'h03F, 9'h08D, 9'h087, 9'h0CB, 9'h03E,
    9'h0F7, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h08B
  };

  // Expected trace per step: {pc, inst, wb_en, wb_addr, wb_data}
  localparam logic [19:0] TRACE [STEPS] = '{
    {4'd0,  9'h050, 1'b1, 2'd1, 4'hF},
    {4'd1,  9'h121, 1'b1, 2'd2, 4'h1},
    {4'd2,  9'h03A, 1'b1, 2'd3, 4'h2},
    {4'd3,  9'h03F, 1'b1, 2'd3, 4'h4},
    {4'd4,  9'h08D, 1'b1, 2'd0, 4'h0},
    {4'd5,  9'h087, 1'b1, 2'd0, 4'h1},
    {4'd6,  9'h0CB, 1'b0, 2'd0, 4'h0},
    {4'd7,  9'h03E, 1'b1, 2'd3, 4'h5},
    {4'd8,  9'h0F7, 1'b0, 2'd0, 4'h0},
    {4'd7,  9'h03E, 1'b1, 2'd3, 4'h6},
    {4'd8,  9'h0F7, 1'b0, 2'd0, 4'h0},
    {4'd7,  9'h03E, 1'b1, 2'd3, 4'h7},
    {4'd8,  9'h0F7, 1'b0, 2'd0, 4'h0},
    {4'd7,  9'h03E, 1'b1, 2'd3, 4'h8},
    {4'd15, 9'h08B, 1'b1, 2'd0, 4'h0},
    {4'd0,  9'h050, 1'b1, 2'd1, 4'hF}
  };

  function automatic string row_req(int k);
    case (k)
      0:           return "R3";
      1:           return "R2";
      4, 5:        return "R4";
      6:           return "R6";
      8, 10, 12:   return "R5";
      13, 14:      return "R7";
      15:          return "R8";
      default:     return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_word(input logic [3:0] a, input logic [8:0] d);
    @(negedge clk);
    load_en   = 1'b1;
    load_addr = a;
    load_data = d;
    @(posedge clk);
    @(negedge clk);
    load_en   = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Phase 1: load while in reset (R10), then run the table
    repeat (2) @(posedge clk);
    for (int w = 0; w < 16; w++) load_word(4'(w), PROG[w]);
    check("R9", "pc in reset", 32'(pc), 32'd0);
    release_reset();

    for (int k = 0; k < STEPS; k++) begin
      check(row_req(k), "pc",   32'(pc),    32'(TRACE[k][19:16]));
      check("R10",      "inst", 32'(inst),  32'(TRACE[k][15:7]));
      check(row_req(k), "wb_en", 32'(wb_en), 32'(TRACE[k][6]));
      if (TRACE[k][6]) begin
        check(row_req(k), "wb_addr", 32'(wb_addr), 32'(TRACE[k][5:4]));
        check(row_req(k), "wb_data", 32'(wb_data), 32'(TRACE[k][3:0]));
      end
      step();
    end
    // R8: step 15 ran at pc 0 and advanced
    check("R8", "pc after wrap", 32'(pc), 32'd1);

    // Phase 2: asynchronous reset mid-run (R9) and reload (R10)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "pc async reset", 32'(pc), 32'd0);
    load_word(4'd0, 9'h0D0);
    load_word(4'd1, 9'h0E0);
    load_word(4'd2, 9'h0F0);
    load_word(4'd3, 9'h010);
    load_word(4'd4, 9'h050);
    load_word(4'd5, 9'h0D0);
    release_reset();

    check("R10", "reloaded inst", 32'(inst), 32'h0D0);
    step();
    check("R9", "r1 cleared (pc)", 32'(pc), 32'd1);
    step();
    check("R9", "r2 cleared (pc)", 32'(pc), 32'd2);
    step();
    check("R9", "r3 cleared (pc)", 32'(pc), 32'd3);
    check("R9", "r0 cleared (wb_data)", 32'(wb_data), 32'd0);
    check("R1", "add wb_addr", 32'(wb_addr), 32'd1);
    step();
    check("R3", "nand of zeros", 32'(wb_data), 32'hF);
    step();
    check("R5", "branch reached", 32'(pc), 32'd5);
    check("R5", "branch no write", 32'(wb_en), 32'd0);

    // R10: load while running must be ignored
    load_en   = 1'b1;
    load_addr = 4'd5;
    load_data = 9'h000;
    step();
    load_en = 1'b0;
    check("R10", "inst after blocked load", 32'(inst), 32'h0D0);
    check("R5", "self branch holds pc", 32'(pc), 32'd5);
    step();
    check("R5", "self branch holds pc again", 32'(pc), 32'd5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule